// File: doc/BRIEF.md
# Stacked-Carrier Multilevel PWM Modulator

This block produces the gate drive for a chain of half-bridge modules whose output voltages add up to form a multilevel staircase. For an output with `LEVELS` levels it forms `LEVELS-1` triangular carriers. Each carrier has the same frequency and the same swing. The carriers are placed one above another in amplitude bands, so that together they cover the signed reference range, centred on zero. On every clock cycle a signed digital reference sample is compared against every carrier. Each comparison drives one complementary pair: an upper switch and a lower switch.

Three phase arrangements of the carriers can be selected. In the first, all bands run in phase. In the second, the bands below zero are inverted relative to the bands above zero. In the third, every band is inverted relative to its neighbours. All carriers are derived from one shared triangle counter. The carrier half-period and the arrangement are sampled only when a carrier period completes, so a change never cuts a pulse short. `LEVELS` is expected to be odd and at least 3. The default of 5 levels gives four bands and four modules.

Top module: `mlpwm_top`

## Requirements
- R1: There are `LEVELS-1` gate pairs. Outside reset, `gate_lo[k]` is always the inverse of `gate_hi[k]`.
- R2: While `rst` is high, every `gate_hi` bit is 0 and every `gate_lo` bit is 1. The triangle restarts at count 0, and the period and mode inputs are captured.
- R3: With a captured half-period P, the shared count steps through 0..2P-1 and then wraps. The triangle value t equals the count while the count is below P, and 2P minus the count after that. The carrier of band k (k=0 is the bottom band) equals (k - (LEVELS-1)/2)*P plus t, or plus P-t if the band is inverted. A `period_in` of 0 is taken as 1.
- R4: `gate_hi[k]` is 1 only when the reference is strictly greater than carrier k. An equal value gives 0. The result appears at the clock edge that closes the cycle in which the reference and the carrier were present.
- R5: Mode code 0 (and the unused code 3) inverts no band.
- R6: Mode code 1 inverts the bands with k < (LEVELS-1)/2, which are the bands below zero, and leaves the bands above zero upright.
- R7: Mode code 2 inverts every band with an odd index k.
- R8: A new mode or period takes effect only on the cycle after the last count (2P-1) of the running period, or out of reset.
- R9: The bands are stacked. If `gate_hi[k+1]` is 1, then `gate_hi[k]` is also 1. A reference above the top band sets every upper gate, and a reference at or below the bottom band clears every upper gate.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ref_in | input | REF_W | Signed reference sample |
| period_in | input | CNT_W | Carrier half-period in clock cycles (0 taken as 1) |
| mode_in | input | 2 | Carrier arrangement: 0 all in phase, 1 lower bands inverted, 2 alternate bands inverted |
| gate_hi | output | LEVELS-1 | Upper switch gates, one per module, bit k = band k |
| gate_lo | output | LEVELS-1 | Lower switch gates, one per module |

## Verification
A shared counter that is out of step, or a band offset that is wrong, shifts the point at which a gate switches relative to the reference. That error reaches the gate pins one clock after the affected count. The bench therefore compares every gate against an independent count model on every cycle and sweeps the reference across all bands. A mode or period captured at the wrong cycle moves a pulse edge within the same carrier period. Mode and period changes are therefore applied in the middle of a period.

// File: rtl/mlpwm_pkg.sv
package mlpwm_pkg;
  typedef enum logic [1:0] {
    ARR_SAME  = 2'd0,
    ARR_SPLIT = 2'd1,
    ARR_ALT   = 2'd2
  } carrier_arr_e;
endpackage

// File: rtl/mlpwm_tri_gen.sv
module mlpwm_tri_gen #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CNT_W-1:0] period_in,
  input  logic [1:0]       mode_in,
  output logic [CNT_W-1:0] tri_o,
  output logic [CNT_W-1:0] per_o,
  output logic [1:0]       mode_o
);
  localparam int PH_W = CNT_W + 1;

  logic [PH_W-1:0]  phase;
  logic [CNT_W-1:0] per_q;
  logic [1:0]       mode_q;
  logic [CNT_W-1:0] per_eff;
  logic [PH_W-1:0]  two_p;
  logic             last;

  assign per_eff = (period_in == '0) ? CNT_W'(1) : period_in;
  assign two_p   = {per_q, 1'b0};
  assign last    = (phase == two_p - PH_W'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      phase  <= '0;
      per_q  <= per_eff;
      mode_q <= mode_in;
    end else if (last) begin
      phase  <= '0;
      per_q  <= per_eff;
      mode_q <= mode_in;
    end else begin
      phase  <= phase + PH_W'(1);
    end
  end

  always_comb begin
    if (phase < {1'b0, per_q}) tri_o = phase[CNT_W-1:0];
    else                       tri_o = CNT_W'(two_p - phase);
  end

  assign per_o  = per_q;
  assign mode_o = mode_q;

  // R3: triangle never leaves its band
  a_r3_tri_bound: assert property (@(posedge clk) disable iff (rst)
    tri_o <= per_q);

  // R8: captured mode and period move only after the last count
  a_r8_mode_hold: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && (mode_q != $past(mode_q))) |-> $past(last));
  a_r8_per_hold: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && (per_q != $past(per_q))) |-> $past(last));
endmodule

// File: rtl/mlpwm_band_cmp.sv
module mlpwm_band_cmp
  import mlpwm_pkg::*;
#(
  parameter int REF_W = 12,
  parameter int CNT_W = 8,
  parameter int NC    = 4,
  parameter int BAND  = 0
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic signed [REF_W-1:0] ref_in,
  input  logic [CNT_W-1:0]        tri_in,
  input  logic [CNT_W-1:0]        per_in,
  input  logic [1:0]              mode_in,
  output logic                    g_hi,
  output logic                    g_lo
);
  localparam int CW   = REF_W + CNT_W + 2;
  localparam int MID  = NC / 2;
  localparam bit BELOW = (BAND < MID);
  localparam bit ODD   = ((BAND % 2) == 1);
  localparam logic signed [CW-1:0] STEP = CW'(BAND - MID);

  logic                 inv;
  logic [CNT_W-1:0]     local_v;
  logic signed [CW-1:0] per_s;
  logic signed [CW-1:0] offset;
  logic signed [CW-1:0] carrier;
  logic signed [CW-1:0] ref_s;
  logic                 above;

  always_comb begin
    case (mode_in)
      ARR_SPLIT: inv = BELOW;
      ARR_ALT:   inv = ODD;
      default:   inv = 1'b0;
    endcase
  end

  assign local_v = inv ? (per_in - tri_in) : tri_in;
  assign per_s   = CW'(per_in);
  assign offset  = per_s * STEP;
  assign carrier = offset + CW'(local_v);
  assign ref_s   = CW'(ref_in);
  assign above   = (ref_s > carrier);

  always_ff @(posedge clk) begin
    if (rst) begin
      g_hi <= 1'b0;
      g_lo <= 1'b1;
    end else begin
      g_hi <= above;
      g_lo <= ~above;
    end
  end

  // R1: the two switches of a module are never on together
  a_r1_complement: assert property (@(posedge clk) disable iff (rst)
    g_hi != g_lo);

  // R2: reset leaves the lower switch on
  a_r2_reset_state: assert property (@(posedge clk)
    rst |=> (g_lo && !g_hi));
endmodule

// File: rtl/mlpwm_top.sv
module mlpwm_top #(
  parameter int LEVELS = 5,
  parameter int REF_W  = 12,
  parameter int CNT_W  = 8
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic signed [REF_W-1:0] ref_in,
  input  logic [CNT_W-1:0]        period_in,
  input  logic [1:0]              mode_in,
  output logic [LEVELS-2:0]       gate_hi,
  output logic [LEVELS-2:0]       gate_lo
);
  localparam int NC = LEVELS - 1;

  logic [CNT_W-1:0] tri_v;
  logic [CNT_W-1:0] per_v;
  logic [1:0]       mode_v;

  mlpwm_tri_gen #(.CNT_W(CNT_W)) tri_i (
    .clk       (clk),
    .rst       (rst),
    .period_in (period_in),
    .mode_in   (mode_in),
    .tri_o     (tri_v),
    .per_o     (per_v),
    .mode_o    (mode_v)
  );

  for (genvar k = 0; k < NC; k++) begin : g_band
    mlpwm_band_cmp #(
      .REF_W (REF_W),
      .CNT_W (CNT_W),
      .NC    (NC),
      .BAND  (k)
    ) band_i (
      .clk     (clk),
      .rst     (rst),
      .ref_in  (ref_in),
      .tri_in  (tri_v),
      .per_in  (per_v),
      .mode_in (mode_v),
      .g_hi    (gate_hi[k]),
      .g_lo    (gate_lo[k])
    );
  end

  for (genvar k = 0; k < NC - 1; k++) begin : g_stack
    // R9: a band can only conduct if every band beneath it does
    a_r9_stack: assert property (@(posedge clk) disable iff (rst)
      gate_hi[k+1] |-> gate_hi[k]);
  end
endmodule

// File: tb/mlpwm_top_tb_top.sv
module mlpwm_top_tb_top;
  localparam int LEVELS = 5;
  localparam int NC     = LEVELS - 1;
  localparam int REF_W  = 12;
  localparam int CNT_W  = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic signed [REF_W-1:0] ref_in = '0;
  logic [CNT_W-1:0] period_in = 8'd5;
  logic [1:0] mode_in = 2'd0;
  logic [NC-1:0] gate_hi, gate_lo;

  int n_vec = 0;
  int n_bad = 0;
  bit done = 1'b0;
  int m_ph = 0, m_per = 1, m_mode = 0;

  always #10 clk = ~clk;

  mlpwm_top #(.LEVELS(LEVELS), .REF_W(REF_W), .CNT_W(CNT_W)) dut_i (
    .clk(clk), .rst(rst), .ref_in(ref_in), .period_in(period_in),
    .mode_in(mode_in), .gate_hi(gate_hi), .gate_lo(gate_lo)
  );

  // one clock: drive at negedge, predict, wait edge, compare at next negedge
  task automatic cycle(input int r, input int p, input int m, input bit rs,
                       input string req);
    logic [NC-1:0] exp_hi;
    int t;
    rst = rs; ref_in = REF_W'(r); period_in = CNT_W'(p); mode_in = 2'(m);
    exp_hi = '0;
    if (rs) begin
      m_ph = 0; m_per = (p == 0) ? 1 : p; m_mode = m;
    end else begin
      t = (m_ph < m_per) ? m_ph : 2 * m_per - m_ph;
      for (int k = 0; k < NC; k++) begin
        bit inv;
        int car;
        inv = (m_mode == 1 && k < NC / 2) || (m_mode == 2 && (k % 2) == 1);
        car = (k - NC / 2) * m_per + (inv ? m_per - t : t);
        exp_hi[k] = (r > car);
      end
      if (m_ph == 2 * m_per - 1) begin
        m_ph = 0; m_per = (p == 0) ? 1 : p; m_mode = m;
      end else m_ph++;
    end
    @(posedge clk);
    @(negedge clk);
    n_vec++;
    if (gate_hi !== exp_hi || gate_lo !== ~exp_hi) begin
      n_bad++;
      $display("FAIL %s: hi=%b lo=%b expected hi=%b lo=%b", req,
               gate_hi, gate_lo, exp_hi, ~exp_hi);
    end
  endtask

  task automatic sweep(input int n, input int p, input int m, input int step,
                       input string req);
    for (int i = 0; i < n; i++) begin
      int a;
      a = 2 * p + 3;
      cycle(((i * step) % (2 * a + 1)) - a, p, m, 1'b0, req);
    end
  endtask

  initial begin
    @(negedge clk);
    for (int i = 0; i < 3; i++) cycle(100, 5, 0, 1'b1, "R2");
    sweep(60, 5, 0, 7, "R5");
    sweep(3, 5, 0, 7, "R4");
    sweep(20, 5, 1, 5, "R8");    // mode change mid-period
    sweep(60, 5, 1, 3, "R6");
    sweep(60, 5, 2, 11, "R7");
    sweep(20, 3, 2, 7, "R8");    // period change mid-period
    sweep(30, 0, 0, 1, "R3");    // period 0 taken as 1
    sweep(40, 7, 3, 13, "R5");   // unused code behaves as code 0
    for (int i = 0; i < 20; i++) cycle(0, 4, 0, 1'b0, "R4");  // ties at zero
    for (int i = 0; i < 16; i++) cycle(2047, 4, 1, 1'b0, "R9");
    for (int i = 0; i < 16; i++) cycle(-2048, 4, 2, 1'b0, "R9");
    for (int i = 0; i < 16; i++) cycle(-8, 4, 0, 1'b0, "R9");  // bottom edge
    for (int i = 0; i < 10; i++) cycle(40, 4, 0, 1'b0, "R1");
    cycle(40, 6, 2, 1'b1, "R2");
    cycle(40, 6, 2, 1'b1, "R2");
    sweep(50, 6, 2, 9, "R3");
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    #2000000;
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end
endmodule